// File: doc/BRIEF.md
# Quarter-wave symmetric staircase level sequencer

This block produces the switching level sequence of a selective-harmonic-elimination modulator for one converter phase. A free-running phase accumulator spans one fundamental period. In each clock the block folds the current phase into the first quarter-wave and compares the folded value against a table of seven stored switching angles. The number of angles already passed decides the output magnitude. The sign comes from the half of the period that the phase is in. Output edges can therefore only occur at the stored angles and at their mirror images across the quarter and half periods.

There are two modes. In three-level mode, every angle toggles the magnitude between 0 and 1. In five-level mode, the first three angles toggle between 0 and 1 (the lower band) and the last four toggle between 1 and 2 (the upper band). Angles are computed elsewhere and loaded through a word-wide write port into a staging table. A commit strobe asks the block to validate that table. A valid table, together with the mode input, becomes active only at the start of a new fundamental period.

The table controller is a three-state machine:
- `T_IDLE` goes to `T_CHECK` on a commit.
- `T_CHECK` goes to `T_ARMED` when the staged table is valid, and back to `T_IDLE` when it is not.
- `T_ARMED` goes to `T_CHECK` on a new commit, or to `T_IDLE` at a period wrap, where the pending table becomes the active table.

Top module: `she_level_seq`

## Requirements
- R1: After reset, `lvl_code` is 0 and `half_cyc` is 0. `lvl_code` stays 0 until a first valid table has become active.
- R2: The phase advances by `phase_step` modulo 2^PH_W on every clock. `half_cyc` is 1 exactly when the phase MSB is 1 (the second half of the period).
- R3: Each angle is an unsigned PH_W-2 bit value, where 2^(PH_W-2) stands for 90 degrees. In the first quarter, the folded phase is the low PH_W-2 phase bits q. In the second quarter, which is selected by phase bit PH_W-2, the folded phase is 2^(PH_W-2) - q. The second half uses the same folding.
- R4: In the second half of the period, the level has the magnitude of the first half with its sign inverted. In the first half the level is never negative.
- R5: The count c is the number of active angles that are less than or equal to the folded phase. In three-level mode (`five_lvl` = 0 when latched), the magnitude is c mod 2, so `lvl_code` stays within -1..1.
- R6: In five-level mode, the magnitude is c mod 2 for c ≤ 3. For c > 3 it is 2 when (c - 3) is odd and 1 when (c - 3) is even.
- R7: A committed table is accepted only if entry 0 is nonzero and each entry is strictly greater than the one before it. A rejected table leaves the active table and the output unchanged.
- R8: An accepted table becomes active at the first period wrap (a phase carry out) that occurs at least two clocks after the commit clock. `five_lvl` is latched at every period wrap. Between wraps, neither the active table nor the mode changes.
- R9: Writes through `ang_we` only change the staging table. They have no effect on the output until a commit is accepted. Writes with `ang_idx` ≥ 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_step | input | PH_W | Phase increment per clock |
| five_lvl | input | 1 | Mode request: 1 for five-level, 0 for three-level; latched at a period wrap |
| ang_we | input | 1 | Staging table write enable |
| ang_idx | input | 3 | Staging table entry index |
| ang_wdata | input | PH_W-2 | Angle value to write |
| tbl_commit | input | 1 | Request validation and activation of the staging table |
| lvl_code | output | 3 | Signed output level, -2..2 |
| half_cyc | output | 1 | High in the second half of the fundamental period |

## Verification
The assertions check on every cycle:
- the sign of the level against the half flag;
- the three-level range limit;
- that the active table is always strictly ordered;
- that the table and the mode can only change on the clock after a period wrap.

The exact edge positions, which come from folding into the second quarter and from splitting the angles between the two bands, are shown only by the bench's cycle-by-cycle reference model. The bench scenarios also cover:
- rejection of unordered tables;
- the two-clock arming delay before a wrap;
- the fact that staged writes are invisible until they are committed.

// File: rtl/she_pkg.sv
package she_pkg;
    typedef enum logic [1:0] {
        T_IDLE  = 2'd0,
        T_CHECK = 2'd1,
        T_ARMED = 2'd2
    } tbl_st_e;
endpackage

// File: rtl/she_phase_acc.sv
module she_phase_acc #(
    parameter int PH_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] step,
    output logic [PH_W-1:0] phase_q,
    output logic            wrap
);
    logic [PH_W-1:0] phase_n;

    // carry out of the accumulator marks the start of a new period
    always_comb begin
        {wrap, phase_n} = {1'b0, phase_q} + {1'b0, step};
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_n;
    end
endmodule

// File: rtl/she_tbl_ctrl.sv
module she_tbl_ctrl
    import she_pkg::*;
#(
    parameter int N  = 7,
    parameter int AW = 14,
    parameter int IW = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IW-1:0]         idx,
    input  logic [AW-1:0]         wdata,
    input  logic                  commit,
    input  logic                  wrap,
    output logic [N-1:0][AW-1:0]  act,
    output logic                  act_valid
);
    tbl_st_e               st, st_n;
    logic [N-1:0][AW-1:0]  stage;
    logic [N-1:0][AW-1:0]  pend;
    logic                  tbl_ok;

    // staged table must start above zero and rise strictly
    always_comb begin
        tbl_ok = (stage[0] != '0);
        for (int i = 1; i < N; i++) begin
            if (stage[i] <= stage[i-1]) tbl_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= T_IDLE;
        else     st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            T_IDLE:  if (commit) st_n = T_CHECK;
            T_CHECK: st_n = tbl_ok ? T_ARMED : T_IDLE;
            T_ARMED: begin
                if (commit)    st_n = T_CHECK;
                else if (wrap) st_n = T_IDLE;
            end
            default: st_n = T_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= '0;
            pend      <= '0;
            act       <= '0;
            act_valid <= 1'b0;
        end else begin
            if (we && int'(idx) < N) stage[idx] <= wdata;
            if (st == T_CHECK && tbl_ok) pend <= stage;
            if (st == T_ARMED && wrap) begin
                act       <= pend;
                act_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/she_level_map.sv
module she_level_map #(
    parameter int PH_W = 16,
    parameter int N    = 7,
    parameter int K    = 3
) (
    input  logic [PH_W-1:0]           phase,
    input  logic [N-1:0][PH_W-3:0]    ang,
    input  logic                      act_valid,
    input  logic                      five,
    output logic signed [2:0]         lvl,
    output logic                      half
);
    localparam int AW = PH_W - 2;
    localparam int CW = $clog2(N + 1);

    logic [AW:0]   folded;
    logic [CW-1:0] cnt;
    logic [CW-1:0] upper;
    logic [1:0]    mag;

    always_comb begin
        // second quarter of each half is mirrored about 90 degrees
        if (phase[PH_W-2]) folded = (AW+1)'(1 << AW) - {1'b0, phase[AW-1:0]};
        else               folded = {1'b0, phase[AW-1:0]};

        cnt = '0;
        for (int i = 0; i < N; i++) begin
            if ({1'b0, ang[i]} <= folded) cnt = cnt + CW'(1);
        end

        upper = cnt - CW'(K);
        if (!five || cnt <= CW'(K)) mag = {1'b0, cnt[0]};
        else                        mag = upper[0] ? 2'd2 : 2'd1;

        half = phase[PH_W-1];
        if (!act_valid)  lvl = 3'sd0;
        else if (half)   lvl = -$signed({1'b0, mag});
        else             lvl = $signed({1'b0, mag});
    end
endmodule

// File: rtl/she_level_seq.sv
module she_level_seq #(
    parameter int PH_W  = 16,
    parameter int N_ANG = 7,
    parameter int K_LOW = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PH_W-1:0]    phase_step,
    input  logic               five_lvl,
    input  logic               ang_we,
    input  logic [2:0]         ang_idx,
    input  logic [PH_W-3:0]    ang_wdata,
    input  logic               tbl_commit,
    output logic signed [2:0]  lvl_code,
    output logic               half_cyc
);
    localparam int ANG_W = PH_W - 2;

    logic [PH_W-1:0]             phase_q;
    logic                        wrap;
    logic [N_ANG-1:0][ANG_W-1:0] act_tbl;
    logic                        act_valid;
    logic                        mode_q;

    she_phase_acc #(.PH_W(PH_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step    (phase_step),
        .phase_q (phase_q),
        .wrap    (wrap)
    );

    she_tbl_ctrl #(.N(N_ANG), .AW(ANG_W), .IW(3)) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .we        (ang_we),
        .idx       (ang_idx),
        .wdata     (ang_wdata),
        .commit    (tbl_commit),
        .wrap      (wrap),
        .act       (act_tbl),
        .act_valid (act_valid)
    );

    // mode is swapped together with the table, only at a period start
    always_ff @(posedge clk) begin
        if (rst)       mode_q <= 1'b0;
        else if (wrap) mode_q <= five_lvl;
    end

    she_level_map #(.PH_W(PH_W), .N(N_ANG), .K(K_LOW)) u_map (
        .phase     (phase_q),
        .ang       (act_tbl),
        .act_valid (act_valid),
        .five      (mode_q),
        .lvl       (lvl_code),
        .half      (half_cyc)
    );
endmodule

// File: rtl/she_level_seq_chk.sv
module she_level_seq_chk #(
    parameter int N  = 7,
    parameter int AW = 14
) (
    input logic                 clk,
    input logic                 rst,
    input logic signed [2:0]    lvl,
    input logic                 half,
    input logic                 mode_q,
    input logic                 wrap,
    input logic                 act_valid,
    input logic [N-1:0][AW-1:0] act_tbl
);
    logic act_rising;

    always_comb begin
        act_rising = (act_tbl[0] != '0);
        for (int i = 1; i < N; i++) begin
            if (act_tbl[i] <= act_tbl[i-1]) act_rising = 1'b0;
        end
    end

    // R1
    no_table_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !act_valid |-> (lvl == 3'sd0));

    // R4
    pos_half_sign_chk: assert property (@(posedge clk) disable iff (rst)
        !half |-> (lvl >= 0));

    // R4
    neg_half_sign_chk: assert property (@(posedge clk) disable iff (rst)
        half |-> (lvl <= 0));

    // R5
    three_lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_q |-> (lvl >= -1 && lvl <= 1));

    // R6
    five_lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> (lvl >= -2 && lvl <= 2));

    // R7
    act_order_chk: assert property (@(posedge clk) disable iff (rst)
        act_valid |-> act_rising);

    // R8
    tbl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(act_tbl) && $stable(mode_q)));
endmodule

bind she_level_seq she_level_seq_chk #(.N(N_ANG), .AW(ANG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lvl       (lvl_code),
    .half      (half_cyc),
    .mode_q    (mode_q),
    .wrap      (wrap),
    .act_valid (act_valid),
    .act_tbl   (act_tbl)
);

// File: tb/tb_she_level_seq.sv
module tb_she_level_seq;
    localparam int PW = 16;
    localparam int AW = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PW-1:0]     phase_step = '0;
    logic              five_lvl = 1'b0;
    logic              ang_we = 1'b0;
    logic [2:0]        ang_idx = '0;
    logic [AW-1:0]     ang_wdata = '0;
    logic              tbl_commit = 1'b0;
    logic signed [2:0] lvl_code;
    logic              half_cyc;

    she_level_seq dut (
        .clk(clk), .rst(rst), .phase_step(phase_step), .five_lvl(five_lvl),
        .ang_we(ang_we), .ang_idx(ang_idx), .ang_wdata(ang_wdata),
        .tbl_commit(tbl_commit), .lvl_code(lvl_code), .half_cyc(half_cyc)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    int unsigned m_phase = 0;
    int  m_act[7];
    int  m_pend[7];
    int  m_stage[7];
    bit  m_valid = 0, m_haspend = 0, m_mode = 0;
    int  edge_n = 0, chk_edge = -1, arm_edge = 0;

    // scoreboard queues
    int    q_lvl[$];
    bit    q_half[$];
    string q_tag[$];

    function automatic bit tbl_valid(input int t[7]);
        if (t[0] == 0) return 0;
        for (int i = 1; i < 7; i++) if (t[i] <= t[i-1]) return 0;
        return 1;
    endfunction

    function automatic int ref_level(input int unsigned ph);
        int q, f, c, mag;
        q = ph % 16384;
        f = ((ph / 16384) % 2 == 1) ? (16384 - q) : q;   // R3 fold
        c = 0;
        for (int i = 0; i < 7; i++) if (m_act[i] <= f) c++;
        if (!m_mode || c <= 3) mag = c % 2;               // R5, R6 lower band
        else mag = ((c - 3) % 2 == 1) ? 2 : 1;            // R6 upper band
        if (!m_valid) return 0;                           // R1
        return (ph >= 32768) ? -mag : mag;                // R4
    endfunction

    // model of one clock edge, using the inputs held across it
    task automatic model_edge();
        bit carry;
        edge_n++;
        carry = (m_phase + phase_step) > 65535;
        if (carry && m_haspend && edge_n >= arm_edge) begin
            m_act = m_pend; m_valid = 1; m_haspend = 0;
        end
        if (chk_edge == edge_n) begin
            if (tbl_valid(m_stage)) begin
                m_pend = m_stage; m_haspend = 1; arm_edge = edge_n + 1;
            end else m_haspend = 0;
        end
        if (tbl_commit) chk_edge = edge_n + 1;
        if (ang_we && ang_idx < 7) m_stage[ang_idx] = ang_wdata;
        if (carry) m_mode = five_lvl;
        m_phase = (m_phase + phase_step) % 65536;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        model_edge();
        q_lvl.push_back(ref_level(m_phase));
        q_half.push_back(m_phase >= 32768);
        q_tag.push_back(cur_req);
        @(negedge clk);
        ang_we = 1'b0;
        tbl_commit = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic load(input int t[7]);
        for (int i = 0; i < 7; i++) begin
            ang_we = 1'b1; ang_idx = 3'(i); ang_wdata = AW'(t[i]);
            cyc();
        end
    endtask

    task automatic commit();
        tbl_commit = 1'b1;
        cyc();
    endtask

    // monitor: compare design outputs against queued expectations
    always @(negedge clk) begin
        if (q_lvl.size() > 0) begin
            int e_l; bit e_h; string tg;
            e_l = q_lvl.pop_front(); e_h = q_half.pop_front(); tg = q_tag.pop_front();
            checks++;
            if (int'(lvl_code) != e_l) begin
                errors++;
                $display("FAIL %s level actual=%0d expected=%0d t=%0t", tg, lvl_code, e_l, $time);
            end
            checks++;
            if (half_cyc != e_h) begin
                errors++;
                $display("FAIL R2 half flag actual=%0b expected=%0b t=%0t", half_cyc, e_h, $time);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t3[7]   = '{1024, 2048, 4096, 6144, 8192, 11264, 14336};
        int t3b[7]  = '{512, 3000, 3500, 7000, 9000, 12500, 16000};
        int t5[7]   = '{1500, 3000, 5200, 7000, 9300, 12000, 15000};
        int bad[7]  = '{1000, 3000, 2500, 6000, 8000, 9000, 10000};
        int zero[7] = '{0, 1000, 2000, 3000, 4000, 5000, 6000};
        for (int i = 0; i < 7; i++) begin m_act[i] = 0; m_pend[i] = 0; m_stage[i] = 0; end

        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (lvl_code != 3'sd0 || half_cyc != 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%0d/%0b expected=0/0", lvl_code, half_cyc);
        end
        rst = 1'b0;
        phase_step = 16'd256;

        // R1, R2: no table yet, level stays 0 while phase runs
        cur_req = "R1";
        run(300);

        // R5, R3, R8: three-level table
        cur_req = "R5";
        load(t3);
        cur_req = "R8";
        commit();
        cur_req = "R3";
        run(600);

        // R9: staged writes without commit change nothing
        cur_req = "R9";
        load(t3b);
        ang_we = 1'b1; ang_idx = 3'd7; ang_wdata = 14'd5;
        cyc();
        run(300);

        // R7: unordered table and zero first angle are rejected
        cur_req = "R7";
        load(bad);
        commit();
        run(300);
        load(zero);
        commit();
        run(300);

        // R6, R8: five-level table and mode, uneven step, commit mid-period
        cur_req = "R6";
        five_lvl = 1'b1;
        phase_step = 16'd300;
        load(t5);
        commit();
        run(900);

        // R8: replace with three-level table near a wrap, odd step
        cur_req = "R8";
        five_lvl = 1'b0;
        phase_step = 16'd77;
        load(t3b);
        commit();
        run(1800);

        // R4: back to five-level, verify sign symmetry across halves
        cur_req = "R4";
        five_lvl = 1'b1;
        phase_step = 16'd128;
        load(t5);
        commit();
        run(1200);

        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule